// File: doc/BRIEF.md
# Debug Register-Access Data Register

This block is the data-register path that lets a JTAG debugger read and write the register file of an on-chip trace buffer. The TAP state machine lives elsewhere. It gives the block one-cycle Capture-DR, Shift-DR and Update-DR indications, TDI, a flag that says the register-access instruction is loaded, and the number of the scan chain currently selected. The path is live only while that instruction is loaded and chain 0 is selected.

One scan image holds a 32-bit data word, a 7-bit register address and a direction bit. At Update-DR the image becomes a single write strobe (direction bit 1) or a single read strobe (direction bit 0) toward the register file, with the address and write data alongside.

Reads are pipelined. The word a read returns is kept in a holding register and comes out on TDO during the next scan. A host therefore ends a read sequence with a harmless read of address 0, so that a register with a side effect on read is not read an extra time. In a RAM dump, every scan reads the auto-incrementing data port except the last one.

Top module: `jtag_regacc_dr`

## Requirements
- R1: While the path is selected, each cycle with the shift indication set moves the 40-bit image one place toward TDO. TDI enters at bit 39. TDO shows bit 0, so data bit 0 leaves first and the direction bit leaves last.
- R2: Image layout is data in bits 31:0, address in bits 38:32 and the direction bit in bit 39. An update with the direction bit at 1 raises `rf_wr` for exactly one cycle, in the cycle after the update. `rf_addr` and `rf_wdata` then carry the scanned address and data.
- R3: An update with the direction bit at 0 raises `rf_rd` for exactly one cycle, in the cycle after the update, with `rf_addr` carrying the scanned address. No write strobe is raised.
- R4: `rf_rdata` is taken into a holding register in the cycle `rf_rd` is high. A later capture loads that held word into image bits 31:0. A write leaves the held word unchanged.
- R5: A capture loads zeros into image bits 39:32, so the address and direction positions shift out as zeros.
- R6: The path is selected only when `instr_hit` is 1 and `scan_chain` equals 0. Otherwise capture, shift and update have no effect, no strobe is raised, and TDO is 0.
- R7: Synchronous reset clears the image, the held read word and both strobes, and holds TDO at 0.
- R8: Strobes are produced only by an update: `rf_rd` and `rf_wr` are never high together, and a scan that ends without an update causes no register access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock domain clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_hit | input | 1 | Register-access instruction is loaded |
| scan_chain | input | CHAIN_W | Currently selected scan chain number |
| tap_capture | input | 1 | TAP is in Capture-DR this cycle |
| tap_shift | input | 1 | TAP is in Shift-DR this cycle |
| tap_update | input | 1 | TAP is in Update-DR this cycle |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| rf_addr | output | 7 | Register file address |
| rf_wdata | output | 32 | Register file write data |
| rf_wr | output | 1 | One-cycle write strobe |
| rf_rd | output | 1 | One-cycle read strobe |
| rf_rdata | input | 32 | Register file read data, valid while rf_rd is high |

## Verification
- **Strobes:** a strobe is due in the cycle after the Update-DR cycle. The bench drives the update at a falling edge and looks for the strobe from the next falling edge onward. It counts strobe cycles across two more falling edges, so a second or late pulse is also caught.
- **Read data:** the word a read returns is due only in the next scan. Each check of read data is therefore made on the TDO bits of the following scan, never on the scan that asked for the read.
- **TDO timing:** TDO holds the bit for the current shift cycle. The bench samples it at the falling edge before the rising edge that shifts.
- **Register file model:** the bench's register file has a pointer that advances on every data-port read. Checking that pointer shows that each update produced exactly one access.

// File: rtl/jtag_regacc_pkg.sv
package jtag_regacc_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 7;
    localparam int DR_W   = DATA_W + ADDR_W + 1;
    localparam int DIR_BIT = DR_W - 1;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DR_W-1:0]   dr_t;

    // Scan image, packed MSB first: direction, address, data (data nearest TDO)
    typedef struct packed {
        logic  is_write;
        addr_t addr;
        word_t data;
    } dr_image_t;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_t;

    typedef struct packed {
        acc_kind_t kind;
        addr_t     addr;
        word_t     wdata;
    } acc_req_t;

    // Image loaded at Capture-DR: held read word, zero header
    function automatic dr_t capture_image(input word_t held);
        dr_image_t img;
        img.is_write = 1'b0;
        img.addr     = '0;
        img.data     = held;
        return dr_t'(img);
    endfunction

    // Turn a shifted-in image into a register file request
    function automatic acc_req_t decode_image(input dr_t raw);
        dr_image_t img;
        acc_req_t  req;
        img       = dr_image_t'(raw);
        req.kind  = img.is_write ? ACC_WRITE : ACC_READ;
        req.addr  = img.addr;
        req.wdata = img.data;
        return req;
    endfunction

endpackage

// File: rtl/jtag_regacc_select.sv
module jtag_regacc_select #(
    parameter int CHAIN_W   = 4,
    parameter int SEL_CHAIN = 0
) (
    input  logic               instr_hit,
    input  logic [CHAIN_W-1:0] scan_chain,
    input  logic               tap_capture,
    input  logic               tap_shift,
    input  logic               tap_update,
    output logic               sel,
    output logic               cap_en,
    output logic               shift_en,
    output logic               upd_en
);
    localparam logic [CHAIN_W-1:0] CHAIN_MATCH = CHAIN_W'(SEL_CHAIN);

    always_comb begin
        sel      = instr_hit && (scan_chain == CHAIN_MATCH);
        cap_en   = sel && tap_capture;
        shift_en = sel && tap_shift && !tap_capture;
        upd_en   = sel && tap_update && !tap_capture && !tap_shift;
    end
endmodule

// File: rtl/jtag_regacc_shreg.sv
module jtag_regacc_shreg
    import jtag_regacc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cap_en,
    input  logic  shift_en,
    input  logic  tdi,
    input  word_t held_word,
    output dr_t   sr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (cap_en) begin
            sr_q <= capture_image(held_word);
        end else if (shift_en) begin
            sr_q <= {tdi, sr_q[DR_W-1:1]};
        end
    end
endmodule

// File: rtl/jtag_regacc_update.sv
module jtag_regacc_update
    import jtag_regacc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     upd_en,
    input  dr_t      sr_q,
    output acc_req_t req_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q.kind  <= ACC_IDLE;
            req_q.addr  <= '0;
            req_q.wdata <= '0;
        end else if (upd_en) begin
            req_q <= decode_image(sr_q);
        end else begin
            // strobe lasts one cycle; address and data stay put
            req_q.kind <= ACC_IDLE;
        end
    end
endmodule

// File: rtl/jtag_regacc_hold.sv
module jtag_regacc_hold
    import jtag_regacc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_strobe,
    input  word_t rdata,
    output word_t hold_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (rd_strobe) begin
            hold_q <= rdata;
        end
    end
endmodule

// File: rtl/jtag_regacc_dr.sv
module jtag_regacc_dr
    import jtag_regacc_pkg::*;
#(
    parameter int CHAIN_W   = 4,
    parameter int SEL_CHAIN = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_hit,
    input  logic [CHAIN_W-1:0] scan_chain,
    input  logic               tap_capture,
    input  logic               tap_shift,
    input  logic               tap_update,
    input  logic               tdi,
    output logic               tdo,
    output logic [ADDR_W-1:0]  rf_addr,
    output logic [DATA_W-1:0]  rf_wdata,
    output logic               rf_wr,
    output logic               rf_rd,
    input  logic [DATA_W-1:0]  rf_rdata
);
    logic     sel;
    logic     cap_en;
    logic     shift_en;
    logic     upd_en;
    dr_t      sr_q;
    word_t    hold_q;
    acc_req_t req_q;

    jtag_regacc_select #(
        .CHAIN_W   (CHAIN_W),
        .SEL_CHAIN (SEL_CHAIN)
    ) u_select (
        .instr_hit   (instr_hit),
        .scan_chain  (scan_chain),
        .tap_capture (tap_capture),
        .tap_shift   (tap_shift),
        .tap_update  (tap_update),
        .sel         (sel),
        .cap_en      (cap_en),
        .shift_en    (shift_en),
        .upd_en      (upd_en)
    );

    jtag_regacc_shreg u_shreg (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (cap_en),
        .shift_en  (shift_en),
        .tdi       (tdi),
        .held_word (hold_q),
        .sr_q      (sr_q)
    );

    jtag_regacc_update u_update (
        .clk    (clk),
        .rst    (rst),
        .upd_en (upd_en),
        .sr_q   (sr_q),
        .req_q  (req_q)
    );

    jtag_regacc_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .rd_strobe (rf_rd),
        .rdata     (rf_rdata),
        .hold_q    (hold_q)
    );

    always_comb begin
        tdo      = sel && !rst && sr_q[0];
        rf_addr  = req_q.addr;
        rf_wdata = req_q.wdata;
        rf_wr    = (req_q.kind == ACC_WRITE);
        rf_rd    = (req_q.kind == ACC_READ);
    end
endmodule

// File: rtl/jtag_regacc_dr_chk.sv
module jtag_regacc_dr_chk
    import jtag_regacc_pkg::*;
#(
    parameter int CHAIN_W   = 4,
    parameter int SEL_CHAIN = 0
) (
    input logic               clk,
    input logic               rst,
    input logic               instr_hit,
    input logic [CHAIN_W-1:0] scan_chain,
    input logic               tap_capture,
    input logic               tap_shift,
    input logic               tap_update,
    input logic               tdi,
    input logic               tdo,
    input logic [ADDR_W-1:0]  rf_addr,
    input logic [DATA_W-1:0]  rf_wdata,
    input logic               rf_wr,
    input logic               rf_rd,
    input dr_t                sr_q,
    input word_t              hold_q
);
    logic path_on;
    assign path_on = instr_hit && (scan_chain == CHAIN_W'(SEL_CHAIN));

    a_r1_shift_step: assert property (@(posedge clk) disable iff (rst)
        (path_on && tap_shift && !tap_capture)
        |=> (sr_q == {$past(tdi), $past(sr_q[DR_W-1:1])}));

    a_r2_write_strobe: assert property (@(posedge clk) disable iff (rst)
        (path_on && tap_update && !tap_capture && !tap_shift && sr_q[DIR_BIT])
        |=> (rf_wr && !rf_rd
             && rf_addr == $past(sr_q[DR_W-2:DATA_W])
             && rf_wdata == $past(sr_q[DATA_W-1:0])));

    a_r3_read_strobe: assert property (@(posedge clk) disable iff (rst)
        (path_on && tap_update && !tap_capture && !tap_shift && !sr_q[DIR_BIT])
        |=> (rf_rd && !rf_wr && rf_addr == $past(sr_q[DR_W-2:DATA_W])));

    a_r4_capture_held: assert property (@(posedge clk) disable iff (rst)
        (path_on && tap_capture) |=> (sr_q[DATA_W-1:0] == $past(hold_q)));

    a_r5_capture_header: assert property (@(posedge clk) disable iff (rst)
        (path_on && tap_capture) |=> (sr_q[DR_W-1:DATA_W] == '0));

    a_r6_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        (!path_on) |=> ($stable(sr_q) && !rf_rd && !rf_wr));

    a_r6_tdo_quiet: assert property (@(posedge clk) disable iff (rst)
        (!path_on) |-> !tdo);

    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rf_rd, rf_wr}));

    a_r8_only_after_update: assert property (@(posedge clk) disable iff (rst)
        !(path_on && tap_update) |=> (!rf_rd && !rf_wr));
endmodule

bind jtag_regacc_dr jtag_regacc_dr_chk #(
    .CHAIN_W   (CHAIN_W),
    .SEL_CHAIN (SEL_CHAIN)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_hit   (instr_hit),
    .scan_chain  (scan_chain),
    .tap_capture (tap_capture),
    .tap_shift   (tap_shift),
    .tap_update  (tap_update),
    .tdi         (tdi),
    .tdo         (tdo),
    .rf_addr     (rf_addr),
    .rf_wdata    (rf_wdata),
    .rf_wr       (rf_wr),
    .rf_rd       (rf_rd),
    .sr_q        (sr_q),
    .hold_q      (hold_q)
);

// File: tb/jtag_regacc_dr_test.sv
module jtag_regacc_dr_test;

    localparam logic [31:0] ID_WORD = 32'h1D0C_0A01;

    typedef struct packed {
        logic        wr;
        logic [6:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    // each entry: one full scan; exp is the word due on TDO in that scan
    localparam vec_t VEC [10] = '{
        '{1'b1, 7'd1, 32'hDEAD_BEEF, 32'h0000_0000},
        '{1'b0, 7'd1, 32'h0,         32'h0000_0000},
        '{1'b0, 7'd0, 32'h0,         32'hDEAD_BEEF},
        '{1'b1, 7'd5, 32'h2,         ID_WORD},
        '{1'b0, 7'd4, 32'h0,         ID_WORD},
        '{1'b0, 7'd4, 32'h0,         32'hA500_0002},
        '{1'b0, 7'd4, 32'h0,         32'hA500_0003},
        '{1'b0, 7'd0, 32'h0,         32'hA500_0004},
        '{1'b0, 7'd5, 32'h0,         ID_WORD},
        '{1'b0, 7'd0, 32'h0,         32'h0000_0005}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        instr_hit;
    logic [3:0]  scan_chain;
    logic        tap_capture;
    logic        tap_shift;
    logic        tap_update;
    logic        tdi;
    logic        tdo;
    logic [6:0]  rf_addr;
    logic [31:0] rf_wdata;
    logic        rf_wr;
    logic        rf_rd;
    logic [31:0] rf_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    jtag_regacc_dr uut (
        .clk         (clk),
        .rst         (rst),
        .instr_hit   (instr_hit),
        .scan_chain  (scan_chain),
        .tap_capture (tap_capture),
        .tap_shift   (tap_shift),
        .tap_update  (tap_update),
        .tdi         (tdi),
        .tdo         (tdo),
        .rf_addr     (rf_addr),
        .rf_wdata    (rf_wdata),
        .rf_wr       (rf_wr),
        .rf_rd       (rf_rd),
        .rf_rdata    (rf_rdata)
    );

    // register file model: 0 id, 1..3 plain, 4 data port with pointer, 5 pointer
    logic [31:0] r1 = '0, r2 = '0, r3 = '0, ptr = '0;

    always_comb begin
        case (rf_addr)
            7'd0:    rf_rdata = ID_WORD;
            7'd1:    rf_rdata = r1;
            7'd2:    rf_rdata = r2;
            7'd3:    rf_rdata = r3;
            7'd4:    rf_rdata = 32'hA500_0000 | ptr;
            7'd5:    rf_rdata = ptr;
            default: rf_rdata = '0;
        endcase
    end

    always @(posedge clk) begin
        if (rf_wr) begin
            case (rf_addr)
                7'd1: r1 <= rf_wdata;
                7'd2: r2 <= rf_wdata;
                7'd3: r3 <= rf_wdata;
                7'd5: ptr <= rf_wdata;
                default: ;
            endcase
        end
        if (rf_rd && rf_addr == 7'd4) ptr <= ptr + 1;
    end

    int          n_rd = 0;
    int          n_wr = 0;
    logic [6:0]  last_wa = '0;
    logic [31:0] last_wd = '0;

    always @(negedge clk) begin
        if (rf_rd) n_rd++;
        if (rf_wr) begin
            n_wr++;
            last_wa = rf_addr;
            last_wd = rf_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic scan(input logic wr, input logic [6:0] a, input logic [31:0] d,
                        input bit upd, output logic [39:0] got,
                        output int drd, output int dwr);
        logic [39:0] img;
        int rd0;
        int wr0;
        img = {wr, a, d};
        rd0 = n_rd;
        wr0 = n_wr;
        @(negedge clk) tap_capture = 1'b1;
        @(negedge clk) tap_capture = 1'b0;
        tap_shift = 1'b1;
        for (int i = 0; i < 40; i++) begin
            tdi    = img[i];
            got[i] = tdo;
            @(negedge clk);
        end
        tap_shift  = 1'b0;
        tap_update = upd;
        @(negedge clk) tap_update = 1'b0;
        @(negedge clk);
        @(negedge clk);
        drd = n_rd - rd0;
        dwr = n_wr - wr0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [39:0] got;
        int drd;
        int dwr;

        rst = 1'b1; instr_hit = 1'b1; scan_chain = 4'd0;
        tap_capture = 1'b0; tap_shift = 1'b0; tap_update = 1'b0; tdi = 1'b0;
        repeat (3) @(negedge clk);
        // R7: reset state
        check(!tdo && !rf_rd && !rf_wr, "R7", "reset outputs",
              {61'd0, tdo, rf_rd, rf_wr}, 64'd0);
        rst = 1'b0;

        // main table
        foreach (VEC[k]) begin
            scan(VEC[k].wr, VEC[k].addr, VEC[k].data, 1'b1, got, drd, dwr);
            check(got[31:0] == VEC[k].exp, "R4", $sformatf("vec%0d captured data", k),
                  64'(got[31:0]), 64'(VEC[k].exp));
            check(got[39:32] == 8'h00, "R5", $sformatf("vec%0d header bits", k),
                  64'(got[39:32]), 64'd0);
            if (VEC[k].wr) begin
                check(dwr == 1 && drd == 0, "R2", $sformatf("vec%0d write strobe count", k),
                      64'(dwr), 64'd1);
                check(last_wa == VEC[k].addr && last_wd == VEC[k].data, "R2",
                      $sformatf("vec%0d write addr/data", k),
                      {25'd0, last_wa, last_wd}, {25'd0, VEC[k].addr, VEC[k].data});
            end else begin
                check(drd == 1 && dwr == 0, "R3", $sformatf("vec%0d read strobe count", k),
                      64'(drd), 64'd1);
            end
        end

        // R1: bit order, a single 1 in data bit 0 leaves first
        scan(1'b1, 7'd3, 32'h0000_0001, 1'b1, got, drd, dwr);
        scan(1'b0, 7'd3, 32'h0, 1'b1, got, drd, dwr);
        scan(1'b0, 7'd0, 32'h0, 1'b1, got, drd, dwr);
        check(got == 40'h00_0000_0001, "R1", "serial order of read word",
              64'(got), 64'h1);

        // R6: deselected by scan chain, then by instruction
        scan_chain = 4'd1;
        scan(1'b1, 7'd2, 32'h1234_5678, 1'b1, got, drd, dwr);
        check(drd == 0 && dwr == 0, "R6", "strobes with other chain",
              64'(drd + dwr), 64'd0);
        check(got == '0, "R6", "tdo with other chain", 64'(got), 64'd0);
        scan_chain = 4'd0;
        instr_hit  = 1'b0;
        scan(1'b1, 7'd2, 32'h1234_5678, 1'b1, got, drd, dwr);
        check(drd == 0 && dwr == 0, "R6", "strobes with other instruction",
              64'(drd + dwr), 64'd0);
        check(got == '0, "R6", "tdo with other instruction", 64'(got), 64'd0);
        instr_hit = 1'b1;
        scan(1'b0, 7'd2, 32'h0, 1'b1, got, drd, dwr);
        scan(1'b0, 7'd0, 32'h0, 1'b1, got, drd, dwr);
        check(got[31:0] == 32'h0, "R6", "register 2 untouched", 64'(got[31:0]), 64'd0);

        // R8: scan ending without update makes no access
        scan(1'b0, 7'd4, 32'h0, 1'b0, got, drd, dwr);
        check(drd == 0 && dwr == 0, "R8", "no update no strobe", 64'(drd + dwr), 64'd0);
        check(got[31:0] == ID_WORD, "R8", "held word after no-update scan",
              64'(got[31:0]), 64'(ID_WORD));
        scan(1'b0, 7'd5, 32'h0, 1'b1, got, drd, dwr);
        scan(1'b0, 7'd0, 32'h0, 1'b1, got, drd, dwr);
        check(got[31:0] == 32'h5, "R8", "data-port pointer unchanged",
              64'(got[31:0]), 64'd5);

        // R7: reset clears held read word
        scan(1'b0, 7'd1, 32'h0, 1'b1, got, drd, dwr);
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        check(!tdo && !rf_rd && !rf_wr, "R7", "outputs in mid-run reset",
              {61'd0, tdo, rf_rd, rf_wr}, 64'd0);
        rst = 1'b0;
        scan(1'b0, 7'd0, 32'h0, 1'b1, got, drd, dwr);
        check(got == '0, "R7", "held word cleared by reset", 64'(got), 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule